// File: doc/BRIEF.md
# Sector-Skipping Codeword Segment Mapper

This block lays out error-corrected codewords over a defect-prone cell array. It cuts the array into equal units of cells and counts the defective cells in each unit. A unit whose count is above a programmable limit is marked unusable, and its cells never hold data. The block then walks the array and builds one segment at a time. Each segment starts on a usable unit boundary and takes cells only from usable units, so a single codeword can cover cells that are not next to each other. The code for each segment is chosen from an ascending table of correction strengths. The chosen code must cover every defect that landed in the segment plus a fixed allowance for transient faults.

For each accepted segment the block emits a record on a valid/ready handshake. The record holds the first unit, the span in units, the selected code, and one inclusion bit per unit of the span. After the last record the block raises `done`. The caller holds the defect bitmap, the limits and the code table stable from `start` until `done`.

Top module: `sector_segmap`

## Requirements
- R1: After reset, `rec_valid` and `done` are 0, and they stay 0 until `start` is pulsed.
- R2: A unit with more than `unit_limit` defective cells is unusable, and its bit in `rec_incl` is 0. A unit with exactly `unit_limit` defects is usable. Bit j of `rec_incl` stands for unit `rec_head`+j.
- R3: Every segment starts at cell 0 of a usable unit. `rec_head` is that unit's index, and bit 0 of `rec_incl` is 1.
- R4: A segment holds exactly `data_bits` + r usable cells, where r is the parity size of the selected code (0 when uncoded). `rec_len` counts the units from `rec_head` through the unit that holds the segment's last cell. No bit of `rec_incl` at or above `rec_len` is set.
- R5: Only defective cells inside the segment's usable units count toward its defect count d. The segment is accepted when d + `margin` is no more than the strength of the current code, which starts as uncoded with strength 0.
- R6: When d + `margin` is above the current strength but no more than the strength of the last table entry, the first table entry i (index order) whose strength is at least that value is selected. Its parity is added to the cell goal, the tail keeps growing, and the test is repeated. `rec_code` is 0 for uncoded and i+1 for entry i.
- R7: When d + `margin` is above the last entry's strength, the attempt is dropped. A new attempt starts at the first usable unit after the dropped head.
- R8: After an accepted segment, the next head is the first usable unit after the unit that holds that segment's last cell.
- R9: An attempt that would take a cell from a unit `SPAN` or more units past its head is dropped in the same way as in R7.
- R10: `done` rises and no further record appears when either of two things happens: the head search passes the last unit, or the tail reaches the end of the array before the cell goal is met. A new `start` runs the whole mapping again.
- R11: While `rec_valid` is 1 and `rec_ready` is 0, the record fields hold their values, and `rec_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts classification and mapping (accepted when idle or done) |
| defect_map | input | N_UNITS*UNIT_CELLS | One bit per cell, 1 = defective |
| unit_limit | input | clog2(UNIT_CELLS+1) | Largest defect count a usable unit may have |
| data_bits | input | KW | User bits per codeword (at least 1) |
| margin | input | TW | Correction strength reserved for transient faults |
| code_t | input | NCODES*TW | Strength of each table entry, entry i at bits i*TW, ascending |
| code_r | input | NCODES*RW | Parity cells of each table entry, entry i at bits i*RW |
| rec_ready | input | 1 | Consumer accepts the record |
| rec_valid | output | 1 | Record available |
| rec_head | output | clog2(N_UNITS+1) | First unit of the segment |
| rec_len | output | clog2(SPAN+1) | Segment span in units |
| rec_code | output | clog2(NCODES+1) | 0 uncoded, i+1 for table entry i |
| rec_incl | output | SPAN | Per-unit inclusion bits of the span |
| done | output | 1 | Mapping finished |

## Verification
The assertions watch properties of every record as it is emitted. They check that the record holds still while it is stalled and that its first unit is usable and included. They check that the span is non-empty and within `SPAN`, that the last included unit closes the span, that the code index is in range, and that no record is shown once `done` is up. The scenarios are needed for the rest: which units get skipped, how far the tail reaches, which code is picked, how the head moves after a dropped attempt, and where the run ends. These results depend on the whole defect bitmap, so they are compared against an independent model, record by record.

// File: rtl/sector_segmap.sv
module sector_segmap #(
  parameter int UNIT_CELLS = 32,
  parameter int N_UNITS    = 16,
  parameter int SPAN       = 64,
  parameter int NCODES     = 8,
  parameter int TW         = 6,
  parameter int RW         = 10,
  parameter int KW         = 12
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [N_UNITS*UNIT_CELLS-1:0]      defect_map,
  input  logic [$clog2(UNIT_CELLS+1)-1:0]    unit_limit,
  input  logic [KW-1:0]                      data_bits,
  input  logic [TW-1:0]                      margin,
  input  logic [NCODES*TW-1:0]               code_t,
  input  logic [NCODES*RW-1:0]               code_r,
  input  logic                               rec_ready,
  output logic                               rec_valid,
  output logic [$clog2(N_UNITS+1)-1:0]       rec_head,
  output logic [$clog2(SPAN+1)-1:0]          rec_len,
  output logic [$clog2(NCODES+1)-1:0]        rec_code,
  output logic [SPAN-1:0]                    rec_incl,
  output logic                               done
);
  localparam int NC  = N_UNITS * UNIT_CELLS;
  localparam int UB  = $clog2(UNIT_CELLS);
  localparam int UW  = $clog2(N_UNITS + 1);
  localparam int PW  = $clog2(NC + 1);
  localparam int CW  = $clog2(UNIT_CELLS + 1);
  localparam int LW  = $clog2(SPAN + 1);
  localparam int IW  = $clog2(NCODES + 1);
  localparam int PKW = $clog2(NCODES);
  localparam int XW0 = (KW > RW) ? KW : RW;
  localparam int XW1 = (XW0 > TW) ? XW0 : TW;
  localparam int GW  = ((XW1 > PW) ? XW1 : PW) + 1;

  typedef enum logic [2:0] {S_IDLE, S_CLASS, S_SEEK, S_SCAN, S_DECIDE, S_EMIT, S_DONE} st_t;

  st_t               st;
  logic [N_UNITS-1:0] usable;
  logic [UW-1:0]     head;
  logic [PW-1:0]     cur;
  logic [GW-1:0]     got, defs;
  logic [TW-1:0]     tcur;
  logic [RW-1:0]     rcur;
  logic [IW-1:0]     code;
  logic [SPAN-1:0]   incl;

  wire [UW-1:0] cur_u  = UW'(cur >> UB);
  wire [UW-1:0] last_u = UW'((cur - PW'(1)) >> UB);
  wire [PW-1:0] off    = PW'(cur_u) - PW'(head);
  wire [PW-1:0] base   = PW'(head) << UB;
  wire [GW-1:0] goal   = GW'(data_bits) + GW'(rcur);
  wire [GW-1:0] need   = defs + GW'(margin);
  wire [TW-1:0] tmax   = code_t[(NCODES-1)*TW +: TW];
  wire [UNIT_CELLS-1:0] uslice = defect_map[base +: UNIT_CELLS];

  logic [CW-1:0] ucount;
  always_comb begin
    ucount = '0;
    for (int i = 0; i < UNIT_CELLS; i++) ucount = ucount + CW'(uslice[i]);
  end

  logic [PKW-1:0] pick;
  always_comb begin
    pick = '0;
    for (int i = NCODES - 1; i >= 0; i--)
      if (GW'(code_t[i*TW +: TW]) >= need) pick = PKW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; usable <= '0; head <= '0; cur <= '0;
      got <= '0; defs <= '0; tcur <= '0; rcur <= '0;
      code <= '0; incl <= '0; done <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_DONE:
          if (start) begin st <= S_CLASS; head <= '0; done <= 1'b0; end
        S_CLASS: begin
          usable[head] <= (ucount <= unit_limit);
          if (head == UW'(N_UNITS - 1)) begin head <= '0; st <= S_SEEK; end
          else head <= head + UW'(1);
        end
        S_SEEK:
          if (head == UW'(N_UNITS)) begin st <= S_DONE; done <= 1'b1; end
          else if (usable[head]) begin
            st <= S_SCAN; cur <= base; got <= '0; defs <= '0;
            tcur <= '0; rcur <= '0; code <= '0; incl <= '0;
          end else head <= head + UW'(1);
        S_SCAN:
          if (got >= goal) st <= S_DECIDE;
          else if (cur == PW'(NC)) begin st <= S_DONE; done <= 1'b1; end
          else if (off >= PW'(SPAN)) begin head <= head + UW'(1); st <= S_SEEK; end
          else if (!usable[cur_u]) cur <= cur + PW'(UNIT_CELLS);
          else begin
            got  <= got + GW'(1);
            defs <= defs + GW'(defect_map[cur]);
            incl <= incl | (SPAN'(1) << off);
            cur  <= cur + PW'(1);
          end
        S_DECIDE:
          if (need <= GW'(tcur)) st <= S_EMIT;
          else if (need <= GW'(tmax)) begin
            tcur <= code_t[pick*TW +: TW];
            rcur <= code_r[pick*RW +: RW];
            code <= IW'(pick) + IW'(1);
            st   <= S_SCAN;
          end else begin head <= head + UW'(1); st <= S_SEEK; end
        S_EMIT:
          if (rec_ready) begin head <= last_u + UW'(1); st <= S_SEEK; end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rec_valid = (st == S_EMIT);
  assign rec_head  = head;
  assign rec_len   = LW'(last_u - head + UW'(1));
  assign rec_code  = code;
  assign rec_incl  = incl;

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid && !rec_ready |=> rec_valid && $stable(rec_head) && $stable(rec_len)
                                && $stable(rec_code) && $stable(rec_incl));
  p_head_used_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_incl[0] && usable[rec_head]);
  p_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_len != '0 && rec_len <= LW'(SPAN));
  p_tail_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_incl[rec_len - LW'(1)] && ((rec_incl >> rec_len) == '0));
  p_code_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_code <= IW'(NCODES));
  p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rec_valid);
endmodule

// File: tb/sector_segmap_test.sv
module sector_segmap_test;
  localparam int UC = 32, NU = 16, SP = 6, NCD = 8, TW = 6, RW = 10, KW = 12;
  localparam int NCELL = UC * NU;

  logic clk = 1'b0;
  logic rst_n, start, rdy;
  logic [NCELL-1:0] dmap;
  logic [$clog2(UC+1)-1:0] thr;
  logic [KW-1:0] kbits;
  logic [TW-1:0] marg;
  logic [NCD*TW-1:0] ct;
  logic [NCD*RW-1:0] cr;
  logic vld, dn;
  logic [$clog2(NU+1)-1:0] head;
  logic [$clog2(SP+1)-1:0] len;
  logic [$clog2(NCD+1)-1:0] code;
  logic [SP-1:0] incl;

  always #10 clk = ~clk;

  sector_segmap #(.UNIT_CELLS(UC), .N_UNITS(NU), .SPAN(SP), .NCODES(NCD),
                  .TW(TW), .RW(RW), .KW(KW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .defect_map(dmap), .unit_limit(thr),
    .data_bits(kbits), .margin(marg), .code_t(ct), .code_r(cr), .rec_ready(rdy),
    .rec_valid(vld), .rec_head(head), .rec_len(len), .rec_code(code),
    .rec_incl(incl), .done(dn));

  int checks = 0, fails = 0;
  int qh[$], ql[$], qc[$];
  logic [SP-1:0] qi[$];

  task automatic chk_eq(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic build_model();
    bit ok_unit[NU];
    int h, c, n, d, t, r, cd, need, tm, cnt;
    logic [SP-1:0] inc;
    bit fail, acc, stop;
    qh.delete(); ql.delete(); qc.delete(); qi.delete();
    for (int u = 0; u < NU; u++) begin
      cnt = 0;
      for (int j = 0; j < UC; j++) cnt += int'(dmap[u*UC+j]);
      ok_unit[u] = (cnt <= int'(thr));
    end
    tm = int'(ct[(NCD-1)*TW +: TW]);
    h = 0; stop = 0;
    while (!stop) begin
      while (h < NU && !ok_unit[h]) h++;
      if (h >= NU) break;
      c = h*UC; n = 0; d = 0; t = 0; r = 0; cd = 0; inc = '0; fail = 0; acc = 0;
      while (!fail && !acc && !stop) begin
        if (n >= int'(kbits) + r) begin
          need = d + int'(marg);
          if (need <= t) acc = 1;
          else if (need <= tm) begin
            for (int i = NCD-1; i >= 0; i--) if (int'(ct[i*TW +: TW]) >= need) cd = i + 1;
            t = int'(ct[(cd-1)*TW +: TW]);
            r = int'(cr[(cd-1)*RW +: RW]);
          end else fail = 1;
        end
        else if (c >= NCELL) stop = 1;
        else if (c/UC - h >= SP) fail = 1;
        else if (!ok_unit[c/UC]) c += UC;
        else begin
          n++; d += int'(dmap[c]); inc[c/UC - h] = 1'b1; c++;
        end
      end
      if (acc) begin
        qh.push_back(h); ql.push_back((c-1)/UC - h + 1); qc.push_back(cd); qi.push_back(inc);
        h = (c-1)/UC + 1;
      end else if (fail) h++;
    end
  endtask

  task automatic run(string tag, int k, int th, int mg, int pct, int hand);
    int seen, cyc, nexp;
    bit pend;
    longint ph, pl, pc, pi;
    seen = 0; cyc = 0; pend = 0; ph = 0; pl = 0; pc = 0; pi = 0;
    @(negedge clk);
    kbits = KW'(k); thr = th[$clog2(UC+1)-1:0]; marg = TW'(mg); rdy = 1'b0;
    build_model();
    nexp = qh.size();
    if (hand >= 0) chk_eq({tag, " model count"}, nexp, hand);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (1) begin
      @(negedge clk);
      cyc++;
      if (pend) begin
        chk_eq({tag, " R11 held valid"}, vld, 1);
        chk_eq({tag, " R11 held head"}, head, ph);
        chk_eq({tag, " R11 held len"}, len, pl);
        chk_eq({tag, " R11 held code"}, code, pc);
        chk_eq({tag, " R11 held incl"}, incl, pi);
        pend = 0;
      end
      if (vld) begin
        if (qh.size() == 0) chk_eq({tag, " R10 unexpected record"}, 1, 0);
        else begin
          chk_eq({tag, " R3 R8 head"}, head, qh[0]);
          chk_eq({tag, " R4 len"}, len, ql[0]);
          chk_eq({tag, " R6 code"}, code, qc[0]);
          chk_eq({tag, " R2 incl"}, incl, qi[0]);
        end
      end
      rdy = ($urandom_range(99) < pct);
      if (vld && rdy) begin
        seen++;
        if (qh.size() > 0) begin
          void'(qh.pop_front()); void'(ql.pop_front());
          void'(qc.pop_front()); void'(qi.pop_front());
        end
      end else if (vld) begin
        pend = 1; ph = head; pl = len; pc = code; pi = incl;
      end
      if (dn) break;
      if (cyc > 40000) begin chk_eq({tag, " watchdog"}, 0, 1); break; end
    end
    chk_eq({tag, " R10 records left"}, qh.size(), 0);
    chk_eq({tag, " R10 record count"}, seen, nexp);
    rdy = 1'b0;
    @(negedge clk);
    chk_eq({tag, " R10 done held"}, dn, 1);
    chk_eq({tag, " R10 no record after done"}, vld, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; rdy = 1'b0; dmap = '0;
    thr = '0; kbits = '0; marg = '0;
    for (int i = 0; i < NCD; i++) begin
      ct[i*TW +: TW] = TW'(i + 1);
      cr[i*RW +: RW] = RW'(11 * (i + 1));
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_eq("R1 valid after reset", vld, 0);
    chk_eq("R1 done after reset", dn, 0);

    // R4 R5 clean array, uncoded segments of two units
    run("R4 clean", 40, 0, 0, 100, 8);
    // R6 margin forces entry 1 (strength 2), code index 2
    run("R6 upgrade", 40, 0, 2, 70, 8);
    // R7 margin above the strongest entry: every attempt dropped
    run("R7 no code", 40, 0, 9, 100, 0);
    // R10 tail runs off the end on the fourth head
    run("R10 tail end", 150, 0, 0, 80, 3);

    // R9 a block of unusable units forces span overflows
    dmap = '0;
    for (int u = 2; u <= 4; u++) for (int j = 0; j < 4; j++) dmap[u*UC + j*5] = 1'b1;
    run("R9 span", 150, 3, 0, 60, 2);

    // R2 R5 unit over the limit skipped, unit at the limit kept and counted
    dmap = '0;
    for (int j = 0; j < 5; j++) dmap[3*UC + j*3] = 1'b1;
    for (int j = 0; j < 3; j++) dmap[7*UC + j] = 1'b1;
    dmap[5] = 1'b1;
    dmap[10*UC + 31] = 1'b1;
    run("R2 R5 skip", 40, 3, 1, 90, -1);

    // R5 R8 random defect field with a stalling consumer
    for (int i = 0; i < NCELL; i++) dmap[i] = ($urandom_range(99) < 4);
    run("R5 R8 random", 60, 2, 1, 50, -1);
    for (int i = 0; i < NCELL; i++) dmap[i] = ($urandom_range(99) < 8);
    run("R7 R9 dense", 50, 3, 2, 40, -1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule